// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out PHY management transactions on a two-wire management bus: a clock line driven by the block and a bidirectional data line. Software loads one 32-bit frame word that packs start, opcode, PHY address, register address, turnaround and 16 data bits. The block then sends 32 preamble ones, followed by the frame word most significant bit first. On a read it releases the data line for the turnaround and the 16 data bit times, and it shifts the bits the PHY returns into the low half of the frame word.

Completion sets a sticky event bit at position 23 of an event register. Software clears it by writing a one to that position. The management clock comes from the system clock through a programmable speed value: one management clock period lasts twice the speed value in system clocks. A speed value of zero stops the clock and keeps the block idle.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 1, `busy` is 0, the frame word reads 0 and the event register reads 0.
- R2: With a nonzero speed value S, `mdc` has a period of 2·S system clocks, with high and low phases of S clocks each.
- R3: Every transaction first drives 32 consecutive ones, with `mdio_oe` high, before any frame bit.
- R4: After the preamble, the 32 frame word bits go out on `mdio_o` from bit 31 down to bit 0, one bit per `mdc` period. Each bit changes on a falling `mdc` edge and is stable across the following rising edge. Layout: [31:30] start (01), [29:28] opcode (10 read, 01 write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data.
- R5: With opcode 10 (read), `mdio_oe` is low for the last 18 bit times. The bits on `mdio_i` at the 16 final rising `mdc` edges are stored, first bit as bit 15, into frame word bits [15:0]. Bits [31:16] keep the written value.
- R6: After a write transaction (any opcode other than 10), the frame word still holds the value that was written.
- R7: Completion sets event register bit 23. The bit stays set until software writes the event register with bit 23 set. A write with bit 23 clear leaves it set.
- R8: A frame word write while `busy` is high is ignored. Neither the stored word nor the frame on the wire changes.
- R9: While the speed value is 0, `mdc` stays low, frame word writes are ignored and no transaction starts.
- R10: `busy` rises at the clock edge that accepts a frame word write. It falls at the falling `mdc` edge that follows the last bit, and `mdio_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_speed | input | SPD_W | Half period of `mdc` in system clocks; 0 disables |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the frame word, 1 selects the event register |
| cfg_wdata | input | 32 | Register write data |
| mgmt_data | output | 32 | Current frame word, including returned read data |
| evt_status | output | 32 | Event register; bit 23 is the completion flag |
| busy | output | 1 | A transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The hardest case to reach from the ports is a frame word write that arrives while a transaction is already shifting. A closely related case is a write accepted on the same clock edge as a falling `mdc` edge, which must still put preamble bit 0 on that edge. The bench reaches the first case by counting `mdc` falls from its own samples and issuing a second frame word write partway through the preamble. It then confirms that the captured wire bits and the stored word both match the original frame. Random speed values, including the fastest setting of 1, move the write strobe through every phase of the divider. At that setting the PHY model must present read data one system clock before the capturing edge.

// File: rtl/mdio_pkg.sv
// Shared constants for the management frame master.
// Assumes a fixed 32-bit frame word and a preamble of all ones.
package mdio_pkg;
    localparam int FRAME_W  = 32;
    localparam int PRE_LEN  = 32;
    localparam int TOTAL_W  = PRE_LEN + FRAME_W;
    localparam int IDX_W    = $clog2(TOTAL_W + 1);
    localparam int OP_HI    = 29;
    localparam int OP_LO    = 28;
    localparam int DATA_W   = 16;
    localparam int TA_POS   = PRE_LEN + 14;
    localparam int DATA_POS = PRE_LEN + 16;
    localparam int EVT_BIT  = 23;
    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
// Management clock divider. Toggles mdc every `speed` system clocks and
// flags the cycle before each rising and falling edge.
// Assumes speed is changed only while no transaction runs.
module mdio_clkdiv #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [SPD_W-1:0] cnt;
    logic             mdc_q;
    logic             at_lim;

    // Divider reaches its limit for the current phase
    assign at_lim    = (speed != '0) && (cnt >= speed - 1'b1);
    assign rise_tick = at_lim && !mdc_q;
    assign fall_tick = at_lim && mdc_q;
    assign mdc       = mdc_q;

    // Phase counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (speed == '0) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (at_lim) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    speed_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == '0) |=> !mdc_q);
    // R2
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed != '0 && !rise_tick && !fall_tick) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_shift.sv
// Serializer for one management transaction: preamble, frame word, and
// on reads the capture of 16 returned bits. Bits change on fall_tick and
// are sampled on rise_tick. Assumes start is raised only while idle.
module mdio_shift
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic               is_rd,
    output logic [DATA_W-1:0]  rd_word
);
    logic [TOTAL_W-1:0] shreg, nxt_bits;
    logic [IDX_W-1:0]   idx, nxt_idx;
    logic               busy_q, rd_q, nxt_rd, active;
    logic               o_q, oe_q;
    logic [DATA_W-1:0]  rd_sh;

    // Source of the next bit: a fresh frame on start, else the shifter
    always_comb begin
        nxt_bits = start ? {{PRE_LEN{1'b1}}, frame_in} : shreg;
        nxt_idx  = start ? '0 : idx;
        nxt_rd   = start ? (frame_in[OP_HI:OP_LO] == OP_READ) : rd_q;
    end

    assign active  = busy_q || start;
    assign done    = fall_tick && busy_q && (idx == IDX_W'(TOTAL_W));
    assign busy    = busy_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;
    assign is_rd   = rd_q;
    assign rd_word = rd_sh;

    // Bit sequencing on falling management clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            idx    <= '0;
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            o_q    <= 1'b1;
            oe_q   <= 1'b0;
        end else if (fall_tick && active) begin
            if (nxt_idx == IDX_W'(TOTAL_W)) begin
                busy_q <= 1'b0;
                idx    <= '0;
                o_q    <= 1'b1;
                oe_q   <= 1'b0;
            end else begin
                o_q    <= nxt_bits[TOTAL_W-1];
                oe_q   <= !(nxt_rd && (nxt_idx >= IDX_W'(TA_POS)));
                shreg  <= nxt_bits << 1;
                idx    <= nxt_idx + 1'b1;
                busy_q <= 1'b1;
                rd_q   <= nxt_rd;
            end
        end else if (start) begin
            shreg  <= nxt_bits;
            idx    <= '0;
            busy_q <= 1'b1;
            rd_q   <= nxt_rd;
        end
    end

    // Read data capture on rising edges during the data bit times
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else if (rise_tick && busy_q && rd_q && (idx > IDX_W'(DATA_POS))) begin
            rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
        end
    end

    // R3
    preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && idx != '0 && idx <= IDX_W'(PRE_LEN)) |-> (o_q && oe_q));
    // R4
    stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> $stable(o_q));
    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_q && idx > IDX_W'(TA_POS)) |-> !oe_q);
    // R10
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !oe_q);
endmodule

// File: rtl/mdio_master.sv
// Management frame master top: holds the frame word and the completion
// event, gates new transactions and joins the divider and the shifter.
// Assumes mdc_speed is changed only while busy is low.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] mdc_speed,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      mgmt_data,
    output logic [31:0]      evt_status,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic              rise_tick, fall_tick, accept, done, is_rd;
    logic [DATA_W-1:0] rd_word;
    logic [31:0]       data_q;
    logic              evt_q;

    // A frame word write starts a transaction only when idle and clocked
    assign accept = cfg_wr && !cfg_sel && !busy && (mdc_speed != '0);

    mdio_clkdiv #(.SPD_W(SPD_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed     (mdc_speed),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .frame_in  (cfg_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .is_rd     (is_rd),
        .rd_word   (rd_word)
    );

    // Frame word: software load, read data return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= cfg_wdata;
        end else if (done && is_rd) begin
            data_q[DATA_W-1:0] <= rd_word;
        end
    end

    // Sticky completion flag, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (done) begin
            evt_q <= 1'b1;
        end else if (cfg_wr && cfg_sel && cfg_wdata[EVT_BIT]) begin
            evt_q <= 1'b0;
        end
    end

    assign mgmt_data  = data_q;
    assign evt_status = {{(31-EVT_BIT){1'b0}}, evt_q, {EVT_BIT{1'b0}}};

    // R7
    done_sets_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt_status[EVT_BIT]);
    // R6
    write_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_rd) |=> $stable(mgmt_data));
    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && !cfg_sel && !done) |=> $stable(mgmt_data));
    // R9
    speed_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_speed == '0 && !busy) |=> (!busy && $stable(mgmt_data)));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mdc_speed = 8'd3;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] mgmt_data, evt_status;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          tests = 0;
    int          fails = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    mdio_master #(.SPD_W(8)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .mdc_speed(mdc_speed), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mgmt_data(mgmt_data),
        .evt_status(evt_status), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_frame(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    endfunction

    function automatic logic [15:0] phy_val(input logic [31:0] f);
        return {f[22:18], f[27:23], f[18], 5'h13} ^ 16'hA5C3;
    endfunction

    task automatic reg_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs one frame with a PHY model; optionally writes a second frame word mid-way
    task automatic run_frame(input logic [31:0] frm, input logic [7:0] spd,
                             input bit inject, input logic [31:0] inj_val);
        logic [31:0] pre_o, pre_oe, fr_o, fr_oe, exp_o, exp_oe, mask;
        logic [15:0] pv;
        logic        prev;
        bit          rd;
        int          falls, cyc, last_rise, per_bad, hi_bad;
        rd = (frm[29:28] == 2'b10);
        pv = phy_val(frm);
        pre_o = '0; pre_oe = '0; fr_o = '0; fr_oe = '0;
        falls = 0; cyc = 0; last_rise = -1; per_bad = 0; hi_bad = 0;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = frm;
        prev = mdc;
        while (falls < 65 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            cfg_wr = 1'b0;
            if (prev == 1'b0 && mdc == 1'b1) begin
                if (last_rise >= 0 && cyc - last_rise != 2 * int'(spd)) per_bad++;
                last_rise = cyc;
                if (falls >= 1 && falls <= 32) begin
                    pre_o[falls-1] = mdio_o; pre_oe[falls-1] = mdio_oe;
                end else if (falls >= 33 && falls <= 64) begin
                    fr_o[64-falls] = mdio_o; fr_oe[64-falls] = mdio_oe;
                end
            end
            if (prev == 1'b1 && mdc == 1'b0) begin
                if (last_rise >= 0 && cyc - last_rise != int'(spd)) hi_bad++;
                falls++;
                if (rd && falls >= 49 && falls <= 64) mdio_i = pv[64-falls];
                else mdio_i = 1'b1;
                if (inject && falls == 10) begin
                    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = inj_val;
                end
            end
            prev = mdc;
        end
        mdio_i = 1'b1;
        exp_oe = rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
        mask   = rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
        exp_o  = frm & mask;
        chk("R2 mdc period", 64'(per_bad), 64'd0);
        chk("R2 mdc high phase", 64'(hi_bad), 64'd0);
        chk("R3 preamble", {pre_oe, pre_o}, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
        chk("R4 frame bits", 64'(fr_o & mask), 64'(exp_o));
        chk(rd ? "R5 output enable" : "R4 output enable", 64'(fr_oe), 64'(exp_oe));
        chk("R10 busy falls at end", {63'd0, busy}, 64'd0);
        chk("R10 idle oe", {63'd0, mdio_oe}, 64'd0);
        chk("R7 event set", 64'(evt_status), 64'h0080_0000);
        if (rd) chk("R5 read data", 64'(mgmt_data), 64'({frm[31:16], pv}));
        else    chk("R6 write keeps word", 64'(mgmt_data), 64'(frm));
        reg_write(1'b1, 32'h0080_0000);
        chk("R7 event cleared", 64'(evt_status), 64'd0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {busy, mdc, mdio_oe, mdio_o, evt_status, mgmt_data[27:0]},
            {4'b0001, 32'd0, 28'd0});
        chk("R1 reset word", 64'(mgmt_data), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed write and read at the fastest speed
        mdc_speed = 8'd1;
        repeat (3) @(negedge clk);
        run_frame(mk_frame(1'b0, 5'd1, 5'd0, 16'h8000), 8'd1, 1'b0, '0);
        run_frame(mk_frame(1'b1, 5'd31, 5'd31, 16'hFFFF), 8'd1, 1'b0, '0);

        // R7 writing zero to the event bit leaves it set
        mdc_speed = 8'd2;
        repeat (3) @(negedge clk);
        reg_write(1'b0, mk_frame(1'b0, 5'd3, 5'd4, 16'h01E1));
        while (busy) @(negedge clk);
        reg_write(1'b1, 32'hFF7F_FFFF);
        chk("R7 zero write keeps event", 64'(evt_status), 64'h0080_0000);
        reg_write(1'b1, 32'h0080_0000);
        chk("R7 cleared by one", 64'(evt_status), 64'd0);

        // R8 write during a running transaction is ignored
        run_frame(mk_frame(1'b0, 5'd5, 5'd9, 16'h1234), 8'd2, 1'b1,
                  mk_frame(1'b1, 5'd0, 5'd0, 16'h0000));
        chk("R8 word after busy write", 64'(mgmt_data), 64'(mk_frame(1'b0, 5'd5, 5'd9, 16'h1234)));

        // R9 speed zero keeps mdc low and ignores frame writes
        mdc_speed = 8'd0;
        repeat (3) @(negedge clk);
        reg_write(1'b0, 32'h6BAD_BEEF);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (mdc || busy || mdio_oe) seen++;
            end
            chk("R9 clock stopped and idle", 64'(seen), 64'd0);
        end
        chk("R9 word unchanged", 64'(mgmt_data), 64'(mk_frame(1'b0, 5'd5, 5'd9, 16'h1234)));
        chk("R9 no event", 64'(evt_status), 64'd0);

        // Random frames at random speeds
        for (int n = 0; n < 10; n++) begin
            logic [7:0]  s;
            logic [31:0] f;
            s = 8'($urandom_range(1, 4));
            f = mk_frame(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom), 16'($urandom));
            mdc_speed = s;
            repeat (2) @(negedge clk);
            run_frame(f, s, 1'b0, '0);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule